// File: doc/BRIEF.md
# Power-loss restore controller

This block decides what a system does when AC power comes back after a loss. Software programs a restore policy into a small register set kept in the battery-backed domain. The block also remembers whether the system was running while standby power was present. When standby power becomes valid again, the block applies the policy and makes one of two choices. It can raise a one-cycle power-on request, or it can leave the system off.

When the choice is "off", an optional pulse feature can drive the active-low power-switch output low for a fixed time of PULSE_SEC seconds. That time is measured in cycles of a clock of CLK_HZ hertz. The pulse stops at once if standby power fails again.

The register port is synchronous. A write lands on the rising clock edge while the write enable is high. Read data is combinational from the address.

Top module: `plr_ctrl`

## Requirements
- R1: After reset, both registers read 0 (policy 00, pulse disabled, preset 0, last state 0), `pwron_req` is 0 and `pwrsw_n` is 1.
- R2: Policy 00 never requests power-on on standby return. Policy 01 always requests it.
- R3: Policy 10 requests power-on exactly when the remembered last state is 1.
- R4: While standby power is valid, the last state follows `pwr_good` from the second standby-valid clock edge onward. While standby power is invalid, the last state is frozen. It reads back as bit 1 of address 1.
- R5: Policy 11 requests power-on exactly when the preset bit (address 1 bit 0) is 1.
- R6: The decision is taken on the first rising clock edge that samples `stby_ok` high. On that same edge `pwron_req` goes high, and it stays high for exactly one cycle.
- R7: If the outcome is "off" and pulse enable (address 0 bit 2) is 1, `pwrsw_n` goes low on the decision edge. It stays low for exactly CLK_HZ*PULSE_SEC cycles. If the outcome is "on", or pulse enable is 0, `pwrsw_n` stays high. `pwron_req` and a low `pwrsw_n` never occur together.
- R8: While `stby_ok` is low, no request is made and no pulse starts. A pulse in progress ends on the first edge that samples `stby_ok` low.
- R9: Address 0 holds the policy in bits [1:0] and pulse enable in bit 2. Address 1 holds the preset in bit 0, which is writable, and the last state in bit 1, which is read-only. All other bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Battery-domain reset, active low, asynchronous assert |
| stby_ok | input | 1 | Standby power valid |
| pwr_good | input | 1 | System main power good |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| pwron_req | output | 1 | One-cycle power-on request |
| pwrsw_n | output | 1 | Power-switch output, active low |

## Verification
Suppose the remembered last state is wrong, or it was not frozen when standby power fell. That error stays hidden until the next standby return under policy 10. It then shows on the decision edge as the wrong choice between a request and a pulse, and it can also be read at once at address 1. A wrong pulse counter shows only at the end of the pulse, as a low time that is too short or too long. A stuck counter therefore needs a full pulse plus a few cycles to appear. An edge detector that is missing or doubled shows within one cycle, as a request that is absent or lasts two cycles.

// File: rtl/plr_pkg.sv
package plr_pkg;
  typedef enum logic [1:0] {
    RST_OFF    = 2'b00,
    RST_ON     = 2'b01,
    RST_LAST   = 2'b10,
    RST_PRESET = 2'b11
  } restore_mode_e;

  typedef struct packed {
    logic          pulse_en;
    restore_mode_e mode;
  } ctl_t;

  localparam int unsigned CTL_W      = $bits(ctl_t);
  localparam int unsigned CTL_ADDR   = 0;
  localparam int unsigned STATE_ADDR = 1;
endpackage

// File: rtl/plr_rst_sync.sv
module plr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/plr_regs.sv
module plr_regs
  import plr_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              last_on,
  output ctl_t              ctl,
  output logic              preset,
  output logic [DATA_W-1:0] rdata
);
  ctl_t ctl_q, ctl_d;
  logic preset_q, preset_d;
  logic ctl_en, preset_en;
  logic sel_ctl, sel_state;
  logic unused_wdata;

  assign sel_ctl   = (addr == ADDR_W'(CTL_ADDR));
  assign sel_state = (addr == ADDR_W'(STATE_ADDR));
  assign unused_wdata = ^wdata[DATA_W-1:CTL_W];

  always_comb begin
    ctl_en    = we && sel_ctl;
    preset_en = we && sel_state;
    ctl_d     = ctl_t'(wdata[CTL_W-1:0]);
    preset_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      preset_q <= 1'b0;
    end else begin
      if (ctl_en)    ctl_q    <= ctl_d;
      if (preset_en) preset_q <= preset_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctl)        rdata[CTL_W-1:0] = ctl_q;
    else if (sel_state) rdata[1:0]       = {last_on, preset_q};
  end

  assign ctl    = ctl_q;
  assign preset = preset_q;
endmodule

// File: rtl/plr_decide.sv
module plr_decide
  import plr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby_ok,
  input  logic          pwr_good,
  input  restore_mode_e mode,
  input  logic          preset,
  output logic          last_on,
  output logic          off_start,
  output logic          pwron_req
);
  logic stby_q;
  logic last_q, last_d, last_en;
  logic req_q, req_d;
  logic rise, steady, want_on;

  assign rise   = stby_ok & ~stby_q;
  assign steady = stby_ok & stby_q;

  always_comb begin
    unique case (mode)
      RST_OFF:    want_on = 1'b0;
      RST_ON:     want_on = 1'b1;
      RST_LAST:   want_on = last_q;
      RST_PRESET: want_on = preset;
      default:    want_on = 1'b0;
    endcase
  end

  always_comb begin
    last_en = steady && (pwr_good != last_q);
    last_d  = pwr_good;
    req_d   = rise & want_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q <= 1'b0;
      last_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      stby_q <= stby_ok;
      req_q  <= req_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign last_on   = last_q;
  assign off_start = rise & ~want_on;
  assign pwron_req = req_q;
endmodule

// File: rtl/plr_pulse.sv
module plr_pulse #(
  parameter int unsigned PULSE_CYC = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_ok,
  input  logic start,
  output logic pwrsw_n
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    upd_en   = active_q | start;
    if (!stby_ok) begin
      active_d = 1'b0;
    end else if (start) begin
      active_d = 1'b1;
      cnt_d    = CNT_W'(PULSE_CYC - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_d = 1'b0;
      else             cnt_d    = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign pwrsw_n = ~active_q;
endmodule

// File: rtl/plr_ctrl.sv
module plr_ctrl
  import plr_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 32768,
  parameter int unsigned PULSE_SEC = 4,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_ok,
  input  logic              pwr_good,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwron_req,
  output logic              pwrsw_n
);
  localparam int unsigned PULSE_CYC = CLK_HZ * PULSE_SEC;

  logic rst_sync_n;
  ctl_t ctl;
  logic preset, last_on, off_start, pulse_en;

  plr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  plr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (reg_addr),
    .we      (reg_we),
    .wdata   (reg_wdata),
    .last_on (last_on),
    .ctl     (ctl),
    .preset  (preset),
    .rdata   (reg_rdata)
  );

  plr_decide u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stby_ok   (stby_ok),
    .pwr_good  (pwr_good),
    .mode      (ctl.mode),
    .preset    (preset),
    .last_on   (last_on),
    .off_start (off_start),
    .pwron_req (pwron_req)
  );

  assign pulse_en = ctl.pulse_en;

  plr_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stby_ok (stby_ok),
    .start   (off_start & pulse_en),
    .pwrsw_n (pwrsw_n)
  );
endmodule

// File: rtl/plr_ctrl_chk.sv
module plr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stby_ok,
  input logic pwron_req,
  input logic pwrsw_n,
  input logic pulse_en,
  input logic last_on
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwron_req |=> !pwron_req); // R6

  AST_REQ_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwron_req && !pwrsw_n)); // R7

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrsw_n) |-> $past(pulse_en)); // R7

  AST_PULSE_NEEDS_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrsw_n |-> $past(stby_ok)); // R8

  AST_REQ_NEEDS_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    pwron_req |-> $past(stby_ok)); // R8

  AST_LAST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stby_ok) |-> $stable(last_on)); // R4
endmodule

bind plr_ctrl plr_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .stby_ok   (stby_ok),
  .pwron_req (pwron_req),
  .pwrsw_n   (pwrsw_n),
  .pulse_en  (pulse_en),
  .last_on   (last_on)
);

// File: tb/sim_plr_ctrl.sv
`timescale 1ns/1ps
module sim_plr_ctrl;
  localparam int unsigned CLK_HZ = 50;
  localparam int unsigned PSEC   = 4;
  localparam int          PCYC   = CLK_HZ * PSEC;
  localparam int unsigned AW = 2;
  localparam int unsigned DW = 8;

  // {mode[1:0], pulse_en, preset, last, exp_req, exp_pulse}
  localparam logic [6:0] VEC [8] = '{
    7'b00_0_0_0_0_0,  // R2 off, no pulse
    7'b00_1_0_1_0_1,  // R2 off, pulse
    7'b01_1_0_0_1_0,  // R2 on
    7'b10_0_0_1_1_0,  // R3 last on
    7'b10_1_0_0_0_1,  // R3 last off, pulse
    7'b10_0_1_0_0_0,  // R3 last off, no pulse
    7'b11_0_1_0_1_0,  // R5 preset on
    7'b11_1_0_1_0_1   // R5 preset off, pulse
  };

  logic clk = 1'b0;
  logic rst_n, stby_ok, pwr_good, reg_we, pwron_req, pwrsw_n;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  plr_ctrl #(.CLK_HZ(CLK_HZ), .PULSE_SEC(PSEC), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .stby_ok(stby_ok), .pwr_good(pwr_good),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwron_req(pwron_req), .pwrsw_n(pwrsw_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // counts low cycles starting at the current negedge
  task automatic count_low(output int n);
    n = 0;
    while (!pwrsw_n && n < PCYC + 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int n;
    rst_n = 1'b0; stby_ok = 1'b1; pwr_good = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, d); chk(d == 0, "R1 ctl reg", d, 0);
    rd(1, d); chk(d == 0, "R1 state reg", d, 0);
    chk(pwron_req == 0, "R1 pwron_req", pwron_req, 0);
    chk(pwrsw_n == 1, "R1 pwrsw_n", pwrsw_n, 1);

    // R9 register map
    @(negedge clk);
    wr(0, 8'hFF); rd(0, d); chk(d == 8'h07, "R9 ctl readback", d, 8'h07);
    wr(1, 8'hFF); rd(1, d); chk(d == 8'h01, "R9 state readback", d, 8'h01);
    wr(2, 8'hFF); rd(2, d); chk(d == 8'h00, "R9 unused addr 2", d, 0);
    rd(3, d); chk(d == 8'h00, "R9 unused addr 3", d, 0);
    wr(0, 8'h00); wr(1, 8'h00);
    rd(0, d); chk(d == 0, "R9 ctl cleared", d, 0);

    // policy vectors
    foreach (VEC[i]) begin
      logic [1:0] m;
      logic en, pre, lst, ereq, epul;
      {m, en, pre, lst, ereq, epul} = VEC[i];
      wr(0, {5'b0, en, m});
      wr(1, {7'b0, pre});
      pwr_good = lst;
      repeat (3) @(negedge clk);
      rd(1, d); chk(d[1] == lst, $sformatf("R4 last tracks v%0d", i), d[1], lst);
      stby_ok = 1'b0; pwr_good = 1'b0;
      repeat (4) @(negedge clk);
      rd(1, d); chk(d[1] == lst, $sformatf("R4 last frozen v%0d", i), d[1], lst);
      stby_ok = 1'b1;
      @(negedge clk);
      chk(pwron_req == ereq, $sformatf("R6 req at decision v%0d", i), pwron_req, ereq);
      chk(pwrsw_n == !epul, $sformatf("R7 pulse start v%0d", i), pwrsw_n, !epul);
      count_low(n);
      if (epul) chk(n == PCYC, $sformatf("R7 pulse length v%0d", i), n, PCYC);
      else begin
        @(negedge clk);
        chk(pwron_req == 0, $sformatf("R6 req one cycle v%0d", i), pwron_req, 0);
      end
      repeat (2) @(negedge clk);
    end

    // R8 nothing while standby invalid; R4 freeze under toggling
    wr(0, 8'h05); // policy 01, pulse enabled
    pwr_good = 1'b1; repeat (3) @(negedge clk);
    stby_ok = 1'b0;
    for (int k = 0; k < 10; k++) begin
      pwr_good = k[0];
      @(negedge clk);
      if (pwron_req || !pwrsw_n) begin
        chk(1'b0, "R8 idle while standby low", {pwron_req, pwrsw_n}, 1);
      end
    end
    checks++;
    rd(1, d); chk(d[1] == 1'b1, "R4 frozen under toggle", d[1], 1);
    pwr_good = 1'b0;

    // R8 pulse abort
    wr(0, 8'h04); // policy 00, pulse enabled
    stby_ok = 1'b1;
    @(negedge clk);
    chk(pwrsw_n == 0, "R8 pulse began", pwrsw_n, 0);
    repeat (20) @(negedge clk);
    stby_ok = 1'b0;
    @(negedge clk);
    chk(pwrsw_n == 1, "R8 pulse aborted", pwrsw_n, 1);
    repeat (5) @(negedge clk);
    chk(pwrsw_n == 1 && pwron_req == 0, "R8 stays idle", pwrsw_n, 1);

    finish_run();
  end
endmodule